// File: doc/BRIEF.md
# Stuff Command Vote Decoder

This block turns a serially received justification command into a per-frame decision: positive stuff, negative stuff or no action. The command field is `FIELD_LEN` bits long and arrives one bit per cycle in which `bit_valid` is high. Each bit is compared against a positive code pattern. The same bit is also compared against the negative pattern, which is the bitwise complement of the positive one. A separate error counter is kept for each pattern. A pattern is accepted while its counter stays below eight, which means the counter's bit 3 is clear.

When the slot strobe arrives, the block registers its decision onto two outputs. These outputs hold until the next strobe. If the vote does not produce exactly one accepted pattern from a complete field, both outputs go low (no action). In that case `cmp_fail` pulses for one cycle, and the diagnostic logic downstream uses that pulse.

A small sequencer tracks where the current field stands. It has three states, and the strobe overrides them all:
- `SEQ_IDLE`: no bit of the field has been taken yet.
- `SEQ_FILL`: some bits have been taken, but fewer than `FIELD_LEN`.
- `SEQ_FULL`: the field is complete, and later bits are ignored.

Transitions:
- IDLE→FILL on the first valid bit.
- FILL→FILL on each further bit.
- FILL→FULL on the last bit.
- On a strobe, any state→IDLE, or any state→FILL when a valid bit arrives in the same cycle.

Top module: `stuff_vote_decoder`

## Requirements
- R1: After reset, `pos_stuff`, `neg_stuff` and `cmp_fail` are low and no field bits are held.
- R2: Received bit i of a field (the i-th valid bit, counting from 0) is compared with bit i of `POS_CODE` for the positive vote, and with the inverse of that bit for the negative vote.
- R3: At a strobe that closes a complete field with fewer than eight mismatches against `POS_CODE`, `pos_stuff` goes high and `neg_stuff` goes low in the next cycle. The two outputs are never high together.
- R4: At a strobe that closes a complete field with fewer than eight mismatches against `~POS_CODE`, `neg_stuff` goes high and `pos_stuff` goes low in the next cycle.
- R5: When neither pattern, or both patterns, are accepted, both outputs go low and `cmp_fail` is high for that one cycle. Each error counter stops at eight.
- R6: `pos_stuff` and `neg_stuff` change only in the cycle after a strobe. `cmp_fail` is high only in the cycle after a strobe.
- R7: A strobe that arrives before `FIELD_LEN` bits have been taken gives no action, and `cmp_fail` is raised.
- R8: Valid bits that arrive after a field is complete and before the next strobe have no effect on the decision.
- R9: When a strobe and a valid bit fall in the same cycle, the decision uses the field received before that cycle. That bit becomes bit 0 of the next field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_bit | input | 1 | Serial command bit |
| bit_valid | input | 1 | `cmd_bit` carries a field bit this cycle |
| slot_strobe | input | 1 | Stuff-command word slot: register the decision |
| pos_stuff | output | 1 | Positive stuff decided |
| neg_stuff | output | 1 | Negative stuff decided |
| cmp_fail | output | 1 | One-cycle pulse: no code accepted |

## Verification
Two functions can fall in the same cycle: closing one field with the slot strobe, and taking the first bit of the next field. The bench provokes this by raising `slot_strobe` together with `bit_valid`, carrying bit 0 of a second field whose expected verdict differs from the first. It judges the result in two places. The outputs one cycle later must show the first field's verdict. After only `FIELD_LEN-1` further bits and another strobe, the outputs must show the second field's verdict, with no failure pulse.

// File: rtl/stuff_vote_pkg.sv
package stuff_vote_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_FILL = 2'd1,
        SEQ_FULL = 2'd2
    } seq_state_t;

    localparam int VOTE_LIMIT = 8;
    localparam int NUM_VOTES  = 2;
endpackage

// File: rtl/stuff_bit_sequencer.sv
module stuff_bit_sequencer
    import stuff_vote_pkg::*;
#(
    parameter int FIELD_LEN = 16,
    localparam int IDX_W    = $clog2(FIELD_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_valid,
    input  logic             slot_strobe,
    output logic             take,
    output logic             first,
    output logic [IDX_W-1:0] bit_pos,
    output logic             complete
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FIELD_LEN - 1);

    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        take    = 1'b0;
        first   = 1'b0;
        if (slot_strobe) begin
            // strobe closes the field; a bit arriving with it opens the next one
            if (bit_valid) begin
                take    = 1'b1;
                first   = 1'b1;
                idx_d   = IDX_W'(1);
                state_d = SEQ_FILL;
            end else begin
                idx_d   = '0;
                state_d = SEQ_IDLE;
            end
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (bit_valid) begin
                        take    = 1'b1;
                        first   = 1'b1;
                        idx_d   = IDX_W'(1);
                        state_d = SEQ_FILL;
                    end
                end
                SEQ_FILL: begin
                    if (bit_valid) begin
                        take = 1'b1;
                        if (idx_q == LAST_IDX) begin
                            idx_d   = '0;
                            state_d = SEQ_FULL;
                        end else begin
                            idx_d = idx_q + IDX_W'(1);
                        end
                    end
                end
                SEQ_FULL: begin
                    idx_d = '0;
                end
                default: begin
                    idx_d   = '0;
                    state_d = SEQ_IDLE;
                end
            endcase
        end
    end

    assign bit_pos  = first ? '0 : idx_q;
    assign complete = (state_q == SEQ_FULL);
endmodule

// File: rtl/stuff_err_counter.sv
module stuff_err_counter #(
    parameter int LIMIT  = 8,
    localparam int CNT_W = $clog2(LIMIT) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             first,
    input  logic             mismatch,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (take) begin
            if (first) begin
                count <= CNT_W'(mismatch);
            end else if (mismatch && (count != CNT_MAX)) begin
                count <= count + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/stuff_vote_decoder.sv
module stuff_vote_decoder
    import stuff_vote_pkg::*;
#(
    parameter int                 FIELD_LEN = 16,
    parameter logic [FIELD_LEN-1:0] POS_CODE = 16'hB38E
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_bit,
    input  logic bit_valid,
    input  logic slot_strobe,
    output logic pos_stuff,
    output logic neg_stuff,
    output logic cmp_fail
);
    localparam int IDX_W = $clog2(FIELD_LEN);
    localparam int CNT_W = $clog2(VOTE_LIMIT) + 1;

    logic             take, first, complete;
    logic [IDX_W-1:0] bit_pos;
    logic [CNT_W-1:0] err_cnt [NUM_VOTES];
    logic [NUM_VOTES-1:0] accept;

    stuff_bit_sequencer #(.FIELD_LEN(FIELD_LEN)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_valid  (bit_valid),
        .slot_strobe(slot_strobe),
        .take       (take),
        .first      (first),
        .bit_pos    (bit_pos),
        .complete   (complete)
    );

    // vote 0 checks the positive pattern, vote 1 its complement
    for (genvar g = 0; g < NUM_VOTES; g++) begin : g_vote
        logic ref_bit;
        assign ref_bit = (g == 0) ? POS_CODE[bit_pos] : ~POS_CODE[bit_pos];

        stuff_err_counter #(.LIMIT(VOTE_LIMIT)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .take    (take),
            .first   (first),
            .mismatch(cmd_bit ^ ref_bit),
            .count   (err_cnt[g])
        );

        assign accept[g] = ~err_cnt[g][CNT_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_stuff <= 1'b0;
            neg_stuff <= 1'b0;
            cmp_fail  <= 1'b0;
        end else if (slot_strobe) begin
            pos_stuff <= complete & accept[0] & ~accept[1];
            neg_stuff <= complete & accept[1] & ~accept[0];
            cmp_fail  <= ~complete | ~(accept[0] ^ accept[1]);
        end else begin
            cmp_fail  <= 1'b0;
        end
    end
endmodule

// File: rtl/stuff_vote_checker.sv
module stuff_vote_checker #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             slot_strobe,
    input logic             complete,
    input logic             pos_stuff,
    input logic             neg_stuff,
    input logic             cmp_fail,
    input logic [CNT_W-1:0] pos_err,
    input logic [CNT_W-1:0] neg_err
);
    p_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(pos_stuff && neg_stuff));

    p_err_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_err <= CNT_W'(8)) && (neg_err <= CNT_W'(8)));

    p_fail_noaction_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_fail |-> (!pos_stuff && !neg_stuff));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_strobe |=> ($stable(pos_stuff) && $stable(neg_stuff)));

    p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_strobe |=> !cmp_fail);

    p_incomplete_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_strobe && !complete) |=> (cmp_fail && !pos_stuff && !neg_stuff));
endmodule

bind stuff_vote_decoder stuff_vote_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_strobe(slot_strobe),
    .complete   (complete),
    .pos_stuff  (pos_stuff),
    .neg_stuff  (neg_stuff),
    .cmp_fail   (cmp_fail),
    .pos_err    (err_cnt[0]),
    .neg_err    (err_cnt[1])
);

// File: tb/stuff_vote_decoder_bench.sv
module stuff_vote_decoder_bench;
    localparam int          N   = 16;
    localparam logic [15:0] POS = 16'hB38E;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_bit = 1'b0, bit_valid = 1'b0, slot_strobe = 1'b0;
    logic pos_stuff, neg_stuff, cmp_fail;
    int checks = 0, errors = 0;
    logic [2:0] last_dec = 3'b000;

    always #10 clk = ~clk;

    stuff_vote_decoder #(.FIELD_LEN(N), .POS_CODE(POS)) u_stuff_vote_decoder (
        .clk(clk), .rst_n(rst_n), .cmd_bit(cmd_bit), .bit_valid(bit_valid),
        .slot_strobe(slot_strobe), .pos_stuff(pos_stuff),
        .neg_stuff(neg_stuff), .cmp_fail(cmp_fail)
    );

    // {pos, neg, fail} expected from the bits taken
    function automatic logic [2:0] expect_dec(logic [15:0] bits, int n);
        int e;
        logic pa, na;
        if (n < N) return 3'b001;
        e  = $countones(bits ^ POS);
        pa = (e < 8);
        na = ((N - e) < 8);
        if (pa && !na) return 3'b100;
        if (na && !pa) return 3'b010;
        return 3'b001;
    endfunction

    task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got {pos,neg,fail}=%b expected %b", req, act, exp);
        end
    endtask

    task automatic put_bit(logic b);
        bit_valid = 1'b1;
        cmd_bit   = b;
        @(negedge clk);
        bit_valid = 1'b0;
        repeat ($urandom_range(0, 2)) @(negedge clk);
    endtask

    task automatic send_bits(logic [15:0] bits, int from, int upto);
        for (int i = from; i < upto; i++) put_bit(bits[i]);
    endtask

    task automatic strobe_check(string req, logic [2:0] exp);
        chk({req, "/R6 hold"}, {pos_stuff, neg_stuff, cmp_fail}, {last_dec[2:1], 1'b0});
        slot_strobe = 1'b1;
        @(negedge clk);
        slot_strobe = 1'b0;
        chk(req, {pos_stuff, neg_stuff, cmp_fail}, exp);
        last_dec = exp;
        @(negedge clk);
        chk("R6 pulse", {pos_stuff, neg_stuff, cmp_fail}, {exp[2:1], 1'b0});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] m, base, f;
        int k;
        void'($urandom(32'd7341));
        repeat (3) @(negedge clk);
        chk("R1 reset", {pos_stuff, neg_stuff, cmp_fail}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);

        send_bits(POS, 0, N);          strobe_check("R3 exact pos", 3'b100);
        send_bits(~POS, 0, N);         strobe_check("R4 exact neg", 3'b010);
        f = POS ^ 16'h007F;            // 7 errors
        send_bits(f, 0, N);            strobe_check("R3 seven errors", expect_dec(f, N));
        f = POS ^ 16'h00FF;            // 8 errors each way
        send_bits(f, 0, N);            strobe_check("R5 tie", 3'b001);
        f = {POS[0], POS[15:1]};       // rotated order
        send_bits(f, 0, N);            strobe_check("R2 bit order", expect_dec(f, N));
        send_bits(POS, 0, 10);         strobe_check("R7 short field", 3'b001);
        send_bits(~POS, 0, N);
        send_bits(POS, 0, 6);          strobe_check("R8 extra bits", 3'b010);

        // R9: strobe with bit 0 of the next field
        send_bits(POS, 0, N);
        chk("R9 hold", {pos_stuff, neg_stuff, cmp_fail}, {last_dec[2:1], 1'b0});
        slot_strobe = 1'b1; bit_valid = 1'b1; cmd_bit = ~POS[0];
        @(negedge clk);
        slot_strobe = 1'b0; bit_valid = 1'b0;
        chk("R9 old field", {pos_stuff, neg_stuff, cmp_fail}, 3'b100);
        last_dec = 3'b100;
        send_bits(~POS, 1, N);         strobe_check("R9 new field", 3'b010);

        for (int it = 0; it < 40; it++) begin
            k = $urandom_range(0, N);
            m = '0;
            while ($countones(m) < k) m[$urandom_range(0, N - 1)] = 1'b1;
            base = ($urandom_range(0, 1) == 1) ? POS : ~POS;
            f = base ^ m;
            send_bits(f, 0, N);
            strobe_check("R2/R3/R4/R5 random", expect_dec(f, N));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule